// File: doc/BRIEF.md
# Frame-Gapped Port Clock Adapter

This block sits between a 2.048 Mbit/s telecom serial backplane bus and one channelized E1 serial port whose only frame reference is a missing burst of clock. The bus delivers a 2.048 MHz bit clock, an active-low frame marker and a data line. Each 125 µs frame holds 32 timeslots of eight bits, sent most significant bit first. The adapter produces a port clock and a port data line. The port clock is the bus clock inverted. It is suppressed for the whole of timeslot 0, so the port locks to the frame by finding the gap.

The bus data travels through an eight-stage register chain clocked by the bus clock. This delays it by exactly one timeslot, so each byte reaches the port in the same clock window that the gap logic assigns to it. Timeslot 0 carries no usable data through the port. A bit counter and a timeslot counter restart whenever the frame marker is sampled low. If the marker stops, they keep running and wrap every 256 bits. The clock enable goes through a latch that is transparent only while the bus clock is high, so the gated clock never shows a runt pulse. When every bus shares one bit clock, a single instance can clock all the ports.

Top module: `fgap_clk_adapter`

## Requirements
- R1: After reset, and until the frame marker `f0_n` is first sampled low on a rising edge of `c2`, `port_clk` stays 0 in every phase.
- R2: `port_clk` is 0 whenever `c2` is high. While `c2` is low, `port_clk` is either 1 (enabled) or 0 (gapped) for the whole low phase.
- R3: A rising edge of `c2` that samples `f0_n` low starts bit 0 of timeslot 0. For that low phase and the next 7 low phases, `port_clk` is 0.
- R4: Once synchronized, `port_clk` is 1 during the `c2` low phase that follows each rising edge falling in timeslots 1 to 31, where the slot index is the number of edges since the marker divided by 8.
- R5: A marker sampled low in the middle of a frame realigns the count at once, and timeslot 0 restarts from that edge.
- R6: With no further marker, the count wraps from bit 7 of timeslot 31 to timeslot 0, and the gap repeats every 256 bits.
- R7: After each rising edge of `c2`, `port_data` equals the `bus_data` sampled 8 rising edges earlier. Bits that entered during reset read as 0.
- R8: A synchronous reset `rst`, sampled high on a rising edge of `c2`, drops synchronization and clears the data chain. The clock then stays gapped until the next marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| c2 | input | 1 | Bus bit clock, 2.048 MHz nominal; also the block clock |
| rst | input | 1 | Synchronous active-high reset, sampled on the `c2` rising edge |
| f0_n | input | 1 | Active-low frame marker, sampled on the `c2` rising edge |
| bus_data | input | 1 | Serial bus data, MSB of each timeslot first |
| port_clk | output | 1 | Inverted `c2`, gapped through timeslot 0 |
| port_data | output | 1 | Bus data delayed by one timeslot (8 bits) |

## Verification
A wrong bit or slot count appears at `port_clk` as a gap at the wrong place or of the wrong length. It is visible within the first low phase whose timeslot class is misjudged, and at the latest at the next frame boundary, 256 edges later. A lost or spurious synchronization flag shows up in the first low phase after the marker or reset. A chain that is too short, too long or broken shows up on `port_data` eight edges after the first random bit enters. The bench compares both outputs in every phase of every clock against a behavioural model.

// File: rtl/fgap_pkg.sv
package fgap_pkg;
  localparam int DEF_BITS_PER_SLOT = 8;
  localparam int DEF_SLOTS         = 32;
  localparam int DEF_DELAY         = 8;
endpackage

// File: rtl/fgap_frame_counter.sv
module fgap_frame_counter #(
  parameter int BITS   = 8,
  parameter int SLOTS  = 32,
  parameter int BIT_W  = $clog2(BITS),
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              f0_n,
  output logic [BIT_W-1:0]  bit_q,
  output logic [SLOT_W-1:0] slot_q,
  output logic              synced_q,
  output logic              open_o
);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(BITS - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q    <= '0;
      slot_q   <= '0;
      synced_q <= 1'b0;
    end else if (!f0_n) begin
      bit_q    <= '0;
      slot_q   <= '0;
      synced_q <= 1'b1;
    end else if (bit_q == LAST_BIT) begin
      bit_q  <= '0;
      slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
    end else begin
      bit_q <= bit_q + 1'b1;
    end
  end

  assign open_o = synced_q && (slot_q != '0);
endmodule

// File: rtl/fgap_clk_gate.sv
module fgap_clk_gate (
  input  logic c2,
  input  logic open_i,
  output logic port_clk
);
  logic en_lat;

  // Transparent while c2 is high; holds through the low phase,
  // which is the phase where port_clk may be high.
  always_latch begin
    if (c2) en_lat = open_i;
  end

  assign port_clk = ~c2 & en_lat;
endmodule

// File: rtl/fgap_data_delay.sv
module fgap_data_delay #(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [DEPTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[DEPTH-2:0], d};
  end

  assign q = chain[DEPTH-1];
endmodule

// File: rtl/fgap_clk_adapter.sv
module fgap_clk_adapter #(
  parameter int BITS_PER_SLOT = fgap_pkg::DEF_BITS_PER_SLOT,
  parameter int SLOTS         = fgap_pkg::DEF_SLOTS,
  parameter int DELAY         = fgap_pkg::DEF_DELAY
) (
  input  logic c2,
  input  logic rst,
  input  logic f0_n,
  input  logic bus_data,
  output logic port_clk,
  output logic port_data
);
  localparam int BIT_W  = $clog2(BITS_PER_SLOT);
  localparam int SLOT_W = $clog2(SLOTS);

  logic [BIT_W-1:0]  bit_q;
  logic [SLOT_W-1:0] slot_q;
  logic              synced_q;
  logic              open_w;

  fgap_frame_counter #(
    .BITS  (BITS_PER_SLOT),
    .SLOTS (SLOTS),
    .BIT_W (BIT_W),
    .SLOT_W(SLOT_W)
  ) u_cnt (
    .clk     (c2),
    .rst     (rst),
    .f0_n    (f0_n),
    .bit_q   (bit_q),
    .slot_q  (slot_q),
    .synced_q(synced_q),
    .open_o  (open_w)
  );

  fgap_clk_gate u_gate (
    .c2      (c2),
    .open_i  (open_w),
    .port_clk(port_clk)
  );

  fgap_data_delay #(.DEPTH(DELAY)) u_dly (
    .clk(c2),
    .rst(rst),
    .d  (bus_data),
    .q  (port_data)
  );
endmodule

// File: rtl/fgap_clk_adapter_chk.sv
module fgap_clk_adapter_chk #(
  parameter int BITS   = 8,
  parameter int SLOTS  = 32,
  parameter int BIT_W  = 3,
  parameter int SLOT_W = 5
) (
  input logic              c2,
  input logic              rst,
  input logic              f0_n,
  input logic [BIT_W-1:0]  bitc,
  input logic [SLOT_W-1:0] slot,
  input logic              synced
);
  a_r3_marker_aligns: assert property (@(posedge c2) disable iff (rst)
    !f0_n |=> (slot == '0 && bitc == '0 && synced));

  a_r6_wraps_to_gap: assert property (@(posedge c2) disable iff (rst)
    (f0_n && slot == SLOT_W'(SLOTS - 1) && bitc == BIT_W'(BITS - 1)) |=> (slot == '0 && bitc == '0));

  a_r4_bit_advance: assert property (@(posedge c2) disable iff (rst)
    (f0_n && bitc != BIT_W'(BITS - 1)) |=> (slot == $past(slot) && bitc == $past(bitc) + 1'b1));

  a_r8_sync_holds: assert property (@(posedge c2) disable iff (rst)
    (f0_n && !synced) |=> !synced);
endmodule

bind fgap_clk_adapter fgap_clk_adapter_chk #(
  .BITS  (BITS_PER_SLOT),
  .SLOTS (SLOTS),
  .BIT_W (BIT_W),
  .SLOT_W(SLOT_W)
) u_chk (
  .c2    (c2),
  .rst   (rst),
  .f0_n  (f0_n),
  .bitc  (bit_q),
  .slot  (slot_q),
  .synced(synced_q)
);

// File: tb/fgap_clk_adapter_tb.sv
`timescale 1ns/100ps
module fgap_clk_adapter_tb;
  logic c2 = 1'b0;
  logic rst = 1'b1;
  logic f0_n = 1'b1;
  logic bus_data = 1'b0;
  logic port_clk, port_data;

  int n_tests = 0;
  int n_fail  = 0;
  string scen = "R1";

  // behavioural reference
  int pos = 0;
  bit synced = 0;
  bit hist[$];

  always #2.5 c2 = ~c2;

  fgap_clk_adapter u_dut (
    .c2(c2), .rst(rst), .f0_n(f0_n), .bus_data(bus_data),
    .port_clk(port_clk), .port_data(port_data)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (%s) t=%0t actual=%b expected=%b", req, scen, $time, act, exp);
    end
  endtask

  task automatic step(input bit r, input bit f, input bit d);
    bit exp_open;
    string cls;
    rst = r; f0_n = f; bus_data = d;
    @(posedge c2);
    if (r) begin
      synced = 0; pos = 0;
      hist.delete();
      for (int i = 0; i < 8; i++) hist.push_back(1'b0);
    end else begin
      if (!f) begin pos = 0; synced = 1; end
      else pos = (pos + 1) % 256;
      hist.push_back(d);
      void'(hist.pop_front());
    end
    #1;
    check("R2", port_clk, 1'b0);
    check("R7", port_data, hist[0]);
    @(negedge c2);
    #1;
    exp_open = synced && (pos / 8 != 0);
    cls = !synced ? "R1" : (pos / 8 == 0 ? "R3" : "R4");
    check(cls, port_clk, exp_open);
  endtask

  task automatic run(input int n, input int f0_every);
    for (int i = 0; i < n; i++)
      step(0, (f0_every > 0 && i % f0_every == 0) ? 1'b0 : 1'b1, 1'($urandom));
  endtask

  initial begin
    @(negedge c2); #1;
    scen = "R1";
    for (int i = 0; i < 3; i++) step(1, 1, 1'($urandom));
    run(300, 0);                 // R1: no marker yet, clock held gapped
    scen = "R3";
    run(512, 256);               // R3/R4: two aligned frames
    scen = "R5";
    run(100, 0);
    run(300, 256);               // R5: early marker realigns mid-frame
    scen = "R6";
    run(600, 0);                 // R6: free-running wrap
    scen = "R8";
    step(1, 1, 1);
    step(1, 1, 0);
    run(60, 0);                  // R8: gapped again after reset
    run(300, 256);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule